// File: doc/BRIEF.md
# Periodic Interval Timer with Wrap Counting

The block generates a regular time base for system software. A free-running prescaler produces one tick every `PRESCALE` clock cycles. On each tick a running interval counter moves up by one until it reaches the programmed period, then returns to zero. Each return to zero adds one to a wrap counter and raises a status flag. The interrupt output follows that flag when software has enabled it.

Software reaches the block through four 32-bit registers: mode, status, value and image. Reading the value register reports the counters and acknowledges the pending wraps. Reading the image register reports the same fields without changing anything. This lets a clock source read elapsed time at any moment without disturbing the tick handler. When the timer is disabled, the current interval runs to completion, so the counter always comes to rest at zero.

Top module: `interval_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: A write to byte address 0x0 (mode) sets the period from bits PERIOD_W-1:0, enable from bit 24 and interrupt enable from bit 25. Reading 0x0 returns these fields in the same positions, with all other bits zero.
- R3: The interval counter changes only on a prescaler tick, one tick every PRESCALE clock cycles counted from reset. It advances while enable is set or while it is non-zero.
- R4: On a tick where the counter is at or above the period, the counter goes to 0, the wrap count rises by one (modulo 2^WRAP_W) and status bit 0 at 0x4 is set. One interval therefore lasts period+1 ticks.
- R5: Address 0x8 (value) reads the wrap count at bits 20 and up and the interval counter at bits PERIOD_W-1:0. A read there clears the wrap count and the status flag.
- R6: Address 0xC (image) reads the same fields as 0x8 and has no side effect.
- R7: If a read of 0x8 lands on the same cycle as a wrap, the wrap count becomes 1 and status stays set.
- R8: After enable is cleared, the counter keeps going until it returns to 0. It then stays at 0.
- R9: `irq` is high exactly when interrupt enable and status are both set. Clearing interrupt enable lowers `irq`, and the counter keeps running.
- R10: Writes to 0x4, 0x8 and 0xC have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (a read of 0x8 acknowledges) |
| busAddr | input | 4 | Byte address; bits 3:2 select the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with PRESCALE=4, PERIOD_W=8 and WRAP_W=4. A tick then comes every four cycles, so a few dozen cycles cover several full intervals, the run-out after disable, and a read that lands exactly on a wrap. The 4-bit wrap count lets a zero period roll the count over modulo 16 within about seventy cycles.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  localparam int ENABLE_BIT = 24;
  localparam int IRQEN_BIT  = 25;
  localparam int WRAP_LSB   = 20;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_STATUS = 2'd1,
    REG_VALUE  = 2'd2,
    REG_IMAGE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic advance;
    logic wrap;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/interval_timer_ctrl.sv
module interval_timer_ctrl
  import interval_timer_pkg::*;
#(
  parameter int PRESCALE = 16,
  parameter int PERIOD_W = 20,
  parameter int WRAP_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [3:0]          busAddr,
  input  logic [31:0]         busWdata,
  input  logic [PERIOD_W-1:0] curVal,
  input  logic [WRAP_W-1:0]   wrapCnt,
  input  logic                status,
  output logic [31:0]         busRdata,
  output logic                irq,
  output logic                enable,
  output strobe_t             stb
);
  localparam int PRESC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESCALE - 1);

  logic [PRESC_W-1:0]  presc;
  logic                tick;
  logic [PERIOD_W-1:0] period;
  logic                irqEn;
  reg_sel_e            regSel;
  logic                running;
  logic                unusedBits;

  assign regSel     = reg_sel_e'(busAddr[3:2]);
  assign unusedBits = ^{busAddr[1:0], busWdata};

  // Free-running prescaler
  assign tick = (presc == PRESC_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     presc <= '0;
    else if (tick) presc <= '0;
    else           presc <= presc + 1'b1;
  end

  // Mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
      enable <= 1'b0;
      irqEn  <= 1'b0;
    end else if (busWr && regSel == REG_MODE) begin
      period <= busWdata[PERIOD_W-1:0];
      enable <= busWdata[ENABLE_BIT];
      irqEn  <= busWdata[IRQEN_BIT];
    end
  end

  // Strobes towards the datapath
  assign running     = enable || (curVal != '0);
  assign stb.advance = tick && running;
  assign stb.wrap    = stb.advance && (curVal >= period);
  assign stb.ack     = busRd && (regSel == REG_VALUE);

  assign irq = irqEn && status;

  // Read mux
  always_comb begin
    busRdata = '0;
    unique case (regSel)
      REG_MODE: begin
        busRdata[PERIOD_W-1:0] = period;
        busRdata[ENABLE_BIT]   = enable;
        busRdata[IRQEN_BIT]    = irqEn;
      end
      REG_STATUS: busRdata[0] = status;
      default: begin
        busRdata[WRAP_LSB +: WRAP_W] = wrapCnt;
        busRdata[PERIOD_W-1:0]       = curVal;
      end
    endcase
  end

  // R2: a mode write lands in the enable state on the next cycle
  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[3:2] == 2'd0) |=> (enable == $past(busWdata[ENABLE_BIT])));

  // R3: ticks are never on two consecutive cycles when the prescale exceeds one
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (PRESCALE > 1 && stb.advance) |=> !stb.advance);
endmodule

// File: rtl/interval_timer_dpath.sv
module interval_timer_dpath
  import interval_timer_pkg::*;
#(
  parameter int PERIOD_W = 20,
  parameter int WRAP_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                enable,
  output logic [PERIOD_W-1:0] curVal,
  output logic [WRAP_W-1:0]   wrapCnt,
  output logic                status
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curVal <= '0;
    else if (stb.wrap)     curVal <= '0;
    else if (stb.advance)  curVal <= curVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrapCnt <= '0;
      status  <= 1'b0;
    end else begin
      unique case ({stb.ack, stb.wrap})
        2'b11: begin wrapCnt <= WRAP_W'(1);      status <= 1'b1; end
        2'b10: begin wrapCnt <= '0;              status <= 1'b0; end
        2'b01: begin wrapCnt <= wrapCnt + 1'b1;  status <= 1'b1; end
        default: ;
      endcase
    end
  end

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(curVal));

  p_wrap_sets_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrap |=> (status && curVal == '0));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.wrap) |=> (wrapCnt == '0 && !status));

  p_ack_meets_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && stb.wrap) |=> (wrapCnt == WRAP_W'(1) && status));

  p_rest_at_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && curVal == '0) |=> (curVal == '0));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int PRESCALE = 16,
  parameter int PERIOD_W = 20,
  parameter int WRAP_W   = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  strobe_t             stb;
  logic                enable;
  logic [PERIOD_W-1:0] curVal;
  logic [WRAP_W-1:0]   wrapCnt;
  logic                status;

  interval_timer_ctrl #(
    .PRESCALE(PRESCALE), .PERIOD_W(PERIOD_W), .WRAP_W(WRAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .curVal(curVal),
    .wrapCnt(wrapCnt), .status(status), .busRdata(busRdata),
    .irq(irq), .enable(enable), .stb(stb)
  );

  interval_timer_dpath #(
    .PERIOD_W(PERIOD_W), .WRAP_W(WRAP_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .enable(enable),
    .curVal(curVal), .wrapCnt(wrapCnt), .status(status)
  );
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int P  = 4;
  localparam int PW = 8;
  localparam int WW = 4;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [15:0] idle;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{K_WR,   4'h0, 32'h0100_0005, 16'd0,  4'd2},  // R2 enable, period 5
    '{K_IDLE, 4'h0, 32'h0,         16'd40, 4'd3},
    '{K_RD,   4'hC, 32'h0,         16'd0,  4'd6},  // R6 image
    '{K_RD,   4'h4, 32'h0,         16'd0,  4'd4},  // R4 status set
    '{K_RD,   4'h8, 32'h0,         16'd0,  4'd5},  // R5 ack
    '{K_RD,   4'hC, 32'h0,         16'd0,  4'd5},  // R5 cleared
    '{K_RD,   4'h4, 32'h0,         16'd0,  4'd5},
    '{K_WR,   4'h0, 32'h0300_0002, 16'd0,  4'd2},  // R2 irq enable, period 2
    '{K_IDLE, 4'h0, 32'h0,         16'd30, 4'd4},
    '{K_RD,   4'h0, 32'h0,         16'd0,  4'd2},  // R2 readback
    '{K_RD,   4'hC, 32'h0,         16'd0,  4'd9},  // R9 irq with status
    '{K_WR,   4'hC, 32'hFFFF_FFFF, 16'd0,  4'd10}, // R10 ignored
    '{K_RD,   4'hC, 32'h0,         16'd0,  4'd10},
    '{K_WR,   4'h4, 32'hFFFF_FFFF, 16'd0,  4'd10}, // R10 ignored
    '{K_RD,   4'h4, 32'h0,         16'd0,  4'd10},
    '{K_RD,   4'h0, 32'h0,         16'd0,  4'd10}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int nChecks = 0, nErrors = 0;

  always #5 clk = ~clk;

  interval_timer #(.PRESCALE(P), .PERIOD_W(PW), .WRAP_W(WW)) u_interval_timer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // Reference model written from the requirements
  logic [1:0]    mPresc;
  logic [PW-1:0] mCur, mPer;
  logic [WW-1:0] mWrap;
  logic          mStat, mEn, mIe;
  always @(posedge clk) begin
    if (!rstN) begin
      mPresc <= '0; mCur <= '0; mPer <= '0; mWrap <= '0;
      mStat <= 1'b0; mEn <= 1'b0; mIe <= 1'b0;
    end else begin
      logic t, adv, w, a;
      t   = (mPresc == 2'(P - 1));
      adv = t && (mEn || mCur != 0);
      w   = adv && (mCur >= mPer);
      a   = busRd && busAddr[3:2] == 2'd2;
      mPresc <= t ? 2'd0 : mPresc + 2'd1;
      if (w) mCur <= '0; else if (adv) mCur <= mCur + 1'b1;
      if (a && w)  begin mWrap <= 1; mStat <= 1'b1; end
      else if (a)  begin mWrap <= 0; mStat <= 1'b0; end
      else if (w)  begin mWrap <= mWrap + 1'b1; mStat <= 1'b1; end
      if (busWr && busAddr[3:2] == 2'd0) begin
        mPer <= busWdata[PW-1:0]; mEn <= busWdata[24]; mIe <= busWdata[25];
      end
    end
  end

  function automatic logic [31:0] expOf(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    case (a[3:2])
      2'd0: begin r[PW-1:0] = mPer; r[24] = mEn; r[25] = mIe; end
      2'd1: r[0] = mStat;
      default: begin r[20 +: WW] = mWrap; r[PW-1:0] = mCur; end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdCheck(input logic [3:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk); busRd = 1'b1; busAddr = a; #1;
    e = expOf(a);
    check(tag, busRdata, e);
    check({tag, " irq"}, 32'(irq), 32'(mIe && mStat));
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, hand-computed zeros
    for (int i = 0; i < 4; i++) begin
      peek(4'(i * 4), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset irq", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_WR:    wrReg(VECS[i].addr, VECS[i].data);
        K_RD:    rdCheck(VECS[i].addr, $sformatf("R%0d vector %0d", VECS[i].req, i));
        default: repeat (VECS[i].idle) @(negedge clk);
      endcase
    end

    // R7: value read on the exact wrap cycle
    wrReg(4'h0, 32'h0100_0002);
    do @(negedge clk); while (!(mPresc == 2'(P - 1) && mCur >= mPer));
    busRd = 1'b1; busAddr = 4'h8;
    @(negedge clk); busRd = 1'b0; busAddr = 4'hC; #1;
    check("R7 wrap count after coincident ack", 32'(busRdata[20 +: WW]), 32'd1);
    busAddr = 4'h4; #1;
    check("R7 status kept", busRdata, 32'd1);

    // R8: disable mid-interval, counter runs out to zero and rests
    repeat (5) @(negedge clk);
    wrReg(4'h0, 32'h0000_0005);
    repeat (40) @(negedge clk);
    peek(4'hC, d);
    check("R8 counter at rest", 32'(d[PW-1:0]), 32'd0);
    repeat (40) @(negedge clk);
    peek(4'hC, d2);
    check("R8 counter stays at rest", d2, d);
    rdCheck(4'hC, "R8 image vs model");

    // R3: start from rest
    wrReg(4'h0, 32'h0100_0005);
    rdCheck(4'hC, "R3 start from rest");
    repeat (9) @(negedge clk);
    rdCheck(4'hC, "R3 counting after start");

    // R9: irq on, then interrupt enable cleared while running
    rdCheck(4'h8, "R9 clear before");
    wrReg(4'h0, 32'h0300_0001);
    repeat (20) @(negedge clk); #1;
    check("R9 irq high", 32'(irq), 32'd1);
    wrReg(4'h0, 32'h0100_0001); #1;
    check("R9 irq low after disable", 32'(irq), 32'd0);
    peek(4'h4, d);
    check("R9 status still set", d, 32'd1);
    peek(4'hC, d);
    repeat (P) @(negedge clk);
    peek(4'hC, d2);
    check("R9 counter still moving", 32'(d2 != d), 32'd1);

    // R4: zero period wraps every tick; wrap count rolls over modulo 16
    rdCheck(4'h8, "R4 clear before rollover");
    wrReg(4'h0, 32'h0100_0000);
    repeat (17 * P) @(negedge clk);
    rdCheck(4'hC, "R4 wrap count rollover");
    rdCheck(4'h4, "R4 status after rollover");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule